// File: doc/BRIEF.md
# I2C Register-Access Target

This block is a serial-bus target that lets an external host read and write a bank of 128 byte-wide registers over I2C. The clock and data lines arrive as plain inputs sampled by the system clock. The block pulls the data line low through an open-drain enable output and never drives it high. Both inputs pass a synchroniser and a glitch filter before any bus edge or condition is decoded.

A transfer opens with a START and the device address. A write puts the low seven bits of the next byte into an internal register pointer. Every later byte is stored at the pointer. A read is reached through a repeated START with the direction bit set, and the target then shifts register contents out. Bit 2 of the control register at index 0x21 decides whether the pointer advances after each byte. When it advances, it wraps from 0x7F to 0x00.

Top module: `i2c_reg_target`

## Requirements
- R1: A falling data line while the clock line is high (START or repeated START) opens an address phase. A rising data line while the clock line is high (STOP) returns the target to idle from any state, and a byte cut short by a STOP is not stored.
- R2: The first byte after a START is compared, MSB first, in its upper seven bits with DEV_ADDR, and its last bit gives the direction (1 = read, 0 = write). On a match the target holds the data line low through the acknowledge clock. Every byte the target receives while addressed is acknowledged the same way.
- R3: A mismatching address gets no acknowledge. The target leaves the data line released until the next START or STOP, and no register changes.
- R4: The byte after a write address loads its bits 6:0 into the register pointer. Bit 7 is ignored.
- R5: Each data byte of a write is stored at the current pointer, and a write may carry any number of bytes before the STOP.
- R6: After an address with direction 1, the target shifts the register at the pointer out MSB first, and it changes the data line only while the clock line is low.
- R7: A host acknowledge (line low) after a read byte makes the target send the next byte. A not-acknowledge (line high) makes it release the line and go idle.
- R8: After each stored or sent byte the pointer advances by one when bit 2 of register 0x21 is 1. When that bit is 0, every byte accesses the same register.
- R9: When advancing, the pointer wraps from 0x7F to 0x00.
- R10: The advance after a byte written to 0x21 follows the value bit 2 had before that byte was stored.
- R11: A pulse on the clock line shorter than FILT_LEN system clocks is ignored.
- R12: After reset all registers read 0x00 except 0x21, which reads 0x04, and the data line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the wire |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls the data line low |

## Verification
Two events can land on the same system-clock edge. The first is a data byte being stored into the control register. The second is the pointer-advance decision for that same byte, which reads the control register. The bench provokes this with a four-byte write starting at 0x20 whose second byte clears the advance bit. It then reads each register back on its own. The third and fourth bytes must both land at 0x22, and 0x23 must stay untouched, which shows the advance used the old control value exactly once.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_filter.sv
module i2c_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic line_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      cnt_q  <= '0;
      line_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], line_i};
      if (sync_q[SYNC_STAGES-1] != line_q) begin
        // accept only after FILT_LEN consecutive differing samples
        if (cnt_q == CW'(FILT_LEN - 1)) begin
          line_q <= sync_q[SYNC_STAGES-1];
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign line_o = line_q;
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o    = scl_q & scl_i & sda_q & ~sda_i;
  assign stop_o     = scl_q & scl_i & ~sda_q & sda_i;
  assign scl_rise_o = ~scl_q & scl_i;
  assign scl_fall_o = scl_q & ~scl_i;
endmodule

// File: rtl/i2c_reg_bank.sv
module i2c_reg_bank #(
  parameter int          AW        = 7,
  parameter int          DW        = 8,
  parameter logic [6:0]  CTRL_ADDR = 7'h21,
  parameter int          INC_BIT   = 2,
  parameter logic [7:0]  CTRL_RST  = 8'h04
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  output logic          inc_en_o
);
  localparam int NREGS = 1 << AW;

  logic [DW-1:0] mem_q [NREGS];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREGS; i++)
        mem_q[i] <= (i == int'(CTRL_ADDR)) ? DW'(CTRL_RST) : '0;
      rdata_q <= '0;
    end else begin
      if (we_i) mem_q[waddr_i] <= wdata_i;
      rdata_q <= mem_q[raddr_i];
    end
  end

  assign rdata_o  = rdata_q;
  assign inc_en_o = mem_q[CTRL_ADDR[AW-1:0]][INC_BIT];
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h1E,
  parameter int         SYNC_STAGES = 2,
  parameter int         FILT_LEN    = 3,
  parameter int         AW          = 7,
  parameter int         DW          = 8,
  parameter logic [6:0] CTRL_ADDR   = 7'h21,
  parameter int         INC_BIT     = 2,
  parameter logic [7:0] CTRL_RST    = 8'h04
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o
);
  localparam int CW = $clog2(DW + 1);

  logic scl_f, sda_f;
  logic start_ev, stop_ev, scl_rise, scl_fall;
  logic [DW-1:0] rd_data;
  logic          inc_en;

  tgt_state_e    state_q;
  logic [CW-1:0] bit_cnt_q;
  logic [DW-1:0] shreg_q;
  logic [AW-1:0] ptr_q;
  logic          rw_q, oe_q;
  logic          we_q;
  logic [AW-1:0] waddr_q;
  logic [DW-1:0] wdata_q;

  i2c_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_scl_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(scl_i), .line_o(scl_f));
  i2c_line_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_sda_filt (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(sda_i), .line_o(sda_f));

  i2c_bus_events u_events (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_i(scl_f), .sda_i(sda_f),
    .start_o(start_ev), .stop_o(stop_ev),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall));

  i2c_reg_bank #(.AW(AW), .DW(DW), .CTRL_ADDR(CTRL_ADDR),
                 .INC_BIT(INC_BIT), .CTRL_RST(CTRL_RST)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .we_i(we_q), .waddr_i(waddr_q), .wdata_i(wdata_q),
    .raddr_i(ptr_q), .rdata_o(rd_data), .inc_en_o(inc_en));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      ptr_q     <= '0;
      rw_q      <= 1'b0;
      oe_q      <= 1'b0;
      we_q      <= 1'b0;
      waddr_q   <= '0;
      wdata_q   <= '0;
    end else begin
      we_q <= 1'b0;
      if (stop_ev) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else if (start_ev) begin
        state_q   <= ST_ADDR;
        oe_q      <= 1'b0;
        bit_cnt_q <= '0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_SUB, ST_WDATA: begin
            if (scl_rise) begin
              shreg_q   <= {shreg_q[DW-2:0], sda_f};
              bit_cnt_q <= bit_cnt_q + 1'b1;
            end else if (scl_fall && bit_cnt_q == CW'(DW)) begin
              bit_cnt_q <= '0;
              if (state_q == ST_ADDR) begin
                if (shreg_q[7:1] == DEV_ADDR) begin
                  rw_q    <= shreg_q[0];
                  oe_q    <= 1'b1;
                  state_q <= ST_ADDR_ACK;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else if (state_q == ST_SUB) begin
                ptr_q   <= shreg_q[AW-1:0];
                oe_q    <= 1'b1;
                state_q <= ST_SUB_ACK;
              end else begin
                we_q    <= 1'b1;
                waddr_q <= ptr_q;
                wdata_q <= shreg_q;
                // decision uses control value before this byte lands
                if (inc_en) ptr_q <= ptr_q + 1'b1;
                oe_q    <= 1'b1;
                state_q <= ST_WDATA_ACK;
              end
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              if (rw_q) begin
                shreg_q   <= rd_data;
                oe_q      <= ~rd_data[DW-1];
                bit_cnt_q <= '0;
                state_q   <= ST_RDATA;
              end else begin
                oe_q    <= 1'b0;
                state_q <= ST_SUB;
              end
            end
          end
          ST_SUB_ACK, ST_WDATA_ACK: begin
            if (scl_fall) begin
              oe_q    <= 1'b0;
              state_q <= ST_WDATA;
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (bit_cnt_q == CW'(DW - 1)) begin
                oe_q    <= 1'b0;
                state_q <= ST_RACK;
                if (inc_en) ptr_q <= ptr_q + 1'b1;
              end else begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
                shreg_q   <= {shreg_q[DW-2:0], 1'b0};
                oe_q      <= ~shreg_q[DW-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise && sda_f) begin
              state_q <= ST_IDLE;
            end else if (scl_fall) begin
              shreg_q   <= rd_data;
              oe_q      <= ~rd_data[DW-1];
              bit_cnt_q <= '0;
              state_q   <= ST_RDATA;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk
  import i2c_tgt_pkg::*;
#(
  parameter int AW = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          sda_oe_i,
  input logic          scl_f_i,
  input logic          start_i,
  input logic          stop_i,
  input tgt_state_e    state_i,
  input logic [AW-1:0] ptr_i
);
  assert_sda_moves_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_i != $past(sda_oe_i)) |-> !$past(scl_f_i));

  assert_idle_released_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE) |-> !sda_oe_i);

  assert_stop_to_idle_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (state_i == ST_IDLE));

  assert_start_to_addr_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !stop_i) |=> (state_i == ST_ADDR));

  assert_addr_ack_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_ADDR_ACK) |-> sda_oe_i);

  assert_ptr_single_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ptr_i != $past(ptr_i)) && ($past(state_i) != ST_SUB))
      |-> (ptr_i == AW'($past(ptr_i) + 1'b1)));
endmodule

bind i2c_reg_target i2c_reg_target_chk #(.AW(AW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sda_oe_i(sda_oe_o),
  .scl_f_i (scl_f),
  .start_i (start_ev),
  .stop_i  (stop_ev),
  .state_i (state_q),
  .ptr_i   (ptr_q)
);

// File: tb/test_i2c_reg_target.sv
module test_i2c_reg_target;
  localparam logic [6:0] DEV = 7'h1E;
  localparam int Q = 8;
  localparam int NV = 6;
  // {sub-address, data}
  localparam logic [15:0] VEC [NV] = '{
    16'h00A5, 16'h853C, 16'h10FF, 16'h7E01, 16'h4080, 16'h135A};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_h = 1'b1, sda_h = 1'b1;
  logic sda_oe;
  logic sda_line;
  assign sda_line = sda_h & ~sda_oe;

  always #2.5 clk = ~clk;

  i2c_reg_target #(.DEV_ADDR(DEV)) i_i2c_reg_target (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_h), .sda_i(sda_line), .sda_oe_o(sda_oe));

  int n_chk = 0, n_fail = 0, hi_moves = 0;
  logic glitch = 1'b0, oe_seen = 1'b0, nack_rel = 1'b0;
  logic [7:0] wbuf [8];
  logic [7:0] rbuf [8];

  always @(negedge clk) if (sda_oe) oe_seen = 1'b1;

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    tick(Q); sda_h = b;
    if (glitch) begin scl_h = 1'b1; tick(1); scl_h = 1'b0; end
    tick(Q); scl_h = 1'b1; tick(2*Q); scl_h = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    tick(Q); sda_h = 1'b1; tick(Q); scl_h = 1'b1; tick(Q);
    b = sda_line;
    tick(Q-1);
    if (sda_line !== b) hi_moves++;
    tick(1); scl_h = 1'b0;
  endtask

  task automatic bus_start;
    tick(Q); sda_h = 1'b1; tick(Q); scl_h = 1'b1; tick(Q); sda_h = 1'b0; tick(Q); scl_h = 1'b0;
  endtask

  task automatic bus_stop;
    tick(Q); sda_h = 1'b0; tick(Q); scl_h = 1'b1; tick(Q); sda_h = 1'b1; tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(b);
    ack = !b;
  endtask

  task automatic recv_byte(output logic [7:0] d, input logic last);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_in(b); d[i] = b; end
    bit_out(last);
  endtask

  task automatic write_regs(input logic [7:0] sub, input int n, input logic gl, output logic all_ack);
    logic a;
    all_ack = 1'b1;
    bus_start;
    send_byte({DEV, 1'b0}, a); all_ack &= a;
    send_byte(sub, a);         all_ack &= a;
    glitch = gl;
    for (int i = 0; i < n; i++) begin send_byte(wbuf[i], a); all_ack &= a; end
    glitch = 1'b0;
    bus_stop;
  endtask

  task automatic read_regs(input logic [7:0] sub, input int n, output logic all_ack);
    logic a;
    all_ack = 1'b1;
    bus_start;
    send_byte({DEV, 1'b0}, a); all_ack &= a;
    send_byte(sub, a);         all_ack &= a;
    bus_start;
    send_byte({DEV, 1'b1}, a); all_ack &= a;
    for (int i = 0; i < n; i++) recv_byte(rbuf[i], i == n - 1);
    tick(Q);
    nack_rel = !sda_oe;
    bus_stop;
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic ok;
    logic b;
    tick(5);
    chk("R12 reset release", {7'd0, sda_oe}, 8'h00);
    rst_n = 1'b1;
    tick(10);

    // R12 reset contents, R2 acks, R8 default advance
    read_regs(8'h20, 2, ok);
    chk("R2 ack", {7'd0, ok}, 8'h01);
    chk("R12 reg 0x20", rbuf[0], 8'h00);
    chk("R12 reg 0x21", rbuf[1], 8'h04);

    // R5/R4 vector table: write one byte, read it back
    for (int v = 0; v < NV; v++) begin
      wbuf[0] = VEC[v][7:0];
      write_regs(VEC[v][15:8], 1, 1'b0, ok);
      chk("R5 write ack", {7'd0, ok}, 8'h01);
      read_regs({1'b0, VEC[v][14:8]}, 1, ok);
      chk("R5/R4 readback", rbuf[0], VEC[v][7:0]);
    end

    // R5/R8/R7 multi-byte write and read with advance
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    write_regs(8'h30, 4, 1'b0, ok);
    read_regs(8'h30, 4, ok);
    for (int i = 0; i < 4; i++) chk("R7 multi read", rbuf[i], 8'h11 * (i + 1));
    chk("R7 nack release", {7'd0, nack_rel}, 8'h01);

    // R9 wrap
    wbuf[0] = 8'hAA; wbuf[1] = 8'hBB;
    write_regs(8'h7F, 2, 1'b0, ok);
    read_regs(8'h7F, 2, ok);
    chk("R9 reg 0x7f", rbuf[0], 8'hAA);
    chk("R9 wrapped reg 0x00", rbuf[1], 8'hBB);

    // R10: byte to 0x21 clears advance; advance for that byte still taken
    wbuf[0] = 8'hC1; wbuf[1] = 8'h00; wbuf[2] = 8'hD1; wbuf[3] = 8'hD2;
    write_regs(8'h20, 4, 1'b0, ok);
    read_regs(8'h20, 1, ok); chk("R10 reg 0x20", rbuf[0], 8'hC1);
    read_regs(8'h21, 1, ok); chk("R10 reg 0x21", rbuf[0], 8'h00);
    read_regs(8'h22, 1, ok); chk("R10 reg 0x22", rbuf[0], 8'hD2);
    read_regs(8'h23, 1, ok); chk("R10 reg 0x23", rbuf[0], 8'h00);
    // R8 no advance on read
    read_regs(8'h30, 2, ok);
    chk("R8 hold read 0", rbuf[0], 8'h11);
    chk("R8 hold read 1", rbuf[1], 8'h11);
    wbuf[0] = 8'h04;
    write_regs(8'h21, 1, 1'b0, ok);

    // R3 foreign address
    oe_seen = 1'b0;
    bus_start;
    send_byte({DEV ^ 7'h01, 1'b0}, ok);
    chk("R3 no ack", {7'd0, ok}, 8'h00);
    send_byte(8'h30, b);
    send_byte(8'hEE, b);
    bus_stop;
    chk("R3 line untouched", {7'd0, oe_seen}, 8'h00);
    read_regs(8'h30, 1, ok);
    chk("R3 reg unchanged", rbuf[0], 8'h11);

    // R11 short clock glitches during data bits
    wbuf[0] = 8'h96;
    write_regs(8'h50, 1, 1'b1, ok);
    read_regs(8'h50, 1, ok);
    chk("R11 glitch rejected", rbuf[0], 8'h96);

    // R1 STOP mid-byte aborts the write
    bus_start;
    send_byte({DEV, 1'b0}, b);
    send_byte(8'h60, b);
    for (int i = 0; i < 4; i++) bit_out(1'b1);
    bus_stop;
    read_regs(8'h60, 1, ok);
    chk("R1 aborted byte", rbuf[0], 8'h00);
    chk("R1 new transfer ack", {7'd0, ok}, 8'h01);

    chk("R6 stable while clock high", hi_moves[7:0], 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule